// File: doc/BRIEF.md
# Management-Bus PHY Discovery Sequencer

After a start pulse, this block finds the first PHY that answers on a station-management bus. It reads the first identifier register at every PHY address, from the lowest address upward. A value of all ones means nothing is fitted at that address. The first address that returns any other value is taken as the responder. The block then reads the second identifier register at that same address and joins the two halves into one 32-bit identifier. It also gives a copy of that identifier with the revision nibble cleared, for comparison against known models.

A PHY may still be in reset when the first sweep runs, so a sweep that finds nothing is repeated. Before each later sweep the block waits a fixed back-off time, counted in clock cycles, and it gives up after a bounded number of sweeps. The serial wire protocol is not part of this block. Register reads go out on a simple request/acknowledge port that a management-frame engine serves. That engine takes the PHY address and register number and returns 16 data bits together with the acknowledge. When discovery ends the block raises a done flag. The flag stays high, together with the found flag, the address and the identifier, until the next start pulse.

Top module: `phy_probe`

## Requirements
- R1: While reset is asserted, and after reset until a start pulse, `mgmt_req`, `done` and `found` are low.
- R2: A start pulse taken while idle or done clears `done`, `found`, `phy_addr`, `phy_id` and `model_id` on the next clock edge. On that same edge the block issues a read of register 2 (the first identifier register) at PHY address 0.
- R3: Within one sweep, register 2 is read at addresses 0, 1, 2 and so on up to 31, in that order. The sweep stops at the first address that responds.
- R4: A register-2 read returning 16'hFFFF means the address is empty. Any other value, including 16'h0000, marks a responder.
- R5: After a responder is found, the next request reads register 3 at the same address. When that read completes, `done` and `found` go high. `phy_addr` then holds the responder's address, and `phy_id` holds the register-2 value in bits 31:16 and the register-3 value in bits 15:0.
- R6: `model_id` equals `phy_id` with bits 3:0 forced to zero.
- R7: Each sweep after the first begins WAIT_MS*CYCLES_PER_MS clock cycles after the acknowledge that ended the previous sweep. During all of those cycles `mgmt_req` is low.
- R8: At most MAX_PASSES (11) sweeps are made. If none finds a responder, `done` goes high with `found`, `phy_addr` and `phy_id` all zero. A responder that first answers in the last sweep is still found.
- R9: A start pulse taken while discovery is running is ignored. The request sequence continues unchanged.
- R10: Only one request is outstanding at a time. Once raised, `mgmt_req` stays high, with `mgmt_phy` and `mgmt_reg` held steady, until the cycle in which `mgmt_ack` is high.
- R11: `done`, `found` and the result outputs hold their values, and `mgmt_req` stays low, until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins discovery |
| mgmt_req | output | 1 | Read request to the management-frame engine |
| mgmt_phy | output | 5 | PHY address of the pending read |
| mgmt_reg | output | 5 | Register number of the pending read |
| mgmt_ack | input | 1 | Read complete, `mgmt_rdata` valid this cycle |
| mgmt_rdata | input | 16 | Data returned by the read |
| done | output | 1 | Discovery finished |
| found | output | 1 | A responder was found |
| phy_addr | output | 5 | Address of the responder |
| phy_id | output | 32 | Joined identifier {reg2, reg3} |
| model_id | output | 32 | Identifier with the revision bits cleared |

## Verification
The bench targets the edges of the sweep. One responder sits at address 31 and only answers from the third sweep onward. Another first answers in the very last allowed sweep. A third run has no responder at all. A design with an off-by-one in the address wrap or the sweep limit either skips address 31, stops one sweep early, or starts a twelfth sweep. Each of these shows up as a mismatch in the request order against the scoreboard. The gap before every later sweep is measured exactly, so a back-off counter that is one cycle short or long is reported. A responder whose first identifier is 16'h0000 catches a design that tests for zero instead of all ones. A start pulse in the middle of a scan catches a design that restarts from address 0.

// File: rtl/phy_probe_pkg.sv
package phy_probe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID_HI,
        ST_ID_LO,
        ST_BACKOFF,
        ST_DONE
    } probe_st_e;

endpackage

// File: rtl/probe_wait_timer.sv
module probe_wait_timer #(
    parameter int WAIT_CYCLES = 10,
    localparam int CNT_W = $clog2(WAIT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CNT_W'(WAIT_CYCLES - 1);
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == '0);

endmodule

// File: rtl/probe_id_pack.sv
module probe_id_pack #(
    parameter int DATA_W   = 16,
    parameter int REV_BITS = 4,
    localparam int ID_W = 2 * DATA_W
) (
    input  logic [DATA_W-1:0] id_hi,
    input  logic [DATA_W-1:0] id_lo,
    output logic [ID_W-1:0]   full_id,
    output logic [ID_W-1:0]   masked_id
);

    assign full_id = {id_hi, id_lo};

    generate
        if (REV_BITS > 0) begin : g_mask
            assign masked_id = {full_id[ID_W-1:REV_BITS], {REV_BITS{1'b0}}};
        end else begin : g_nomask
            assign masked_id = full_id;
        end
    endgenerate

endmodule

// File: rtl/phy_probe.sv
module phy_probe
    import phy_probe_pkg::*;
#(
    parameter int ADDR_W        = 5,
    parameter int REG_W         = 5,
    parameter int DATA_W        = 16,
    parameter int CYCLES_PER_MS = 100000,
    parameter int WAIT_MS       = 10,
    parameter int MAX_PASSES    = 11,
    parameter int ID1_REG       = 2,
    parameter int ID2_REG       = 3,
    parameter int REV_BITS      = 4,
    localparam int ID_W         = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              mgmt_req,
    output logic [ADDR_W-1:0] mgmt_phy,
    output logic [REG_W-1:0]  mgmt_reg,
    input  logic              mgmt_ack,
    input  logic [DATA_W-1:0] mgmt_rdata,
    output logic              done,
    output logic              found,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [ID_W-1:0]   phy_id,
    output logic [ID_W-1:0]   model_id
);

    localparam int              WAIT_CYCLES = WAIT_MS * CYCLES_PER_MS;
    localparam int              PASS_W      = $clog2(MAX_PASSES + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
    localparam logic [DATA_W-1:0] ABSENT    = {DATA_W{1'b1}};

    typedef struct packed {
        probe_st_e          st;
        logic [ADDR_W-1:0]  addr;
        logic [PASS_W-1:0]  pass;
        logic [DATA_W-1:0]  id_hi;
        logic [DATA_W-1:0]  id_lo;
        logic               found;
        logic [ADDR_W-1:0]  res_addr;
    } core_t;

    core_t core_d, core_q;
    logic  wait_load;
    logic  wait_over;

    always_comb begin
        core_d    = core_q;
        wait_load = 1'b0;
        unique case (core_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    core_d.st       = ST_ID_HI;
                    core_d.addr     = '0;
                    core_d.pass     = '0;
                    core_d.id_hi    = '0;
                    core_d.id_lo    = '0;
                    core_d.found    = 1'b0;
                    core_d.res_addr = '0;
                end
            end
            ST_ID_HI: begin
                if (mgmt_ack) begin
                    if (mgmt_rdata != ABSENT) begin
                        core_d.id_hi = mgmt_rdata;
                        core_d.st    = ST_ID_LO;
                    end else if (core_q.addr != LAST_ADDR) begin
                        core_d.addr = core_q.addr + 1'b1;
                    end else if (core_q.pass == PASS_W'(MAX_PASSES - 1)) begin
                        core_d.st = ST_DONE;
                    end else begin
                        core_d.addr = '0;
                        core_d.pass = core_q.pass + 1'b1;
                        core_d.st   = ST_BACKOFF;
                        wait_load   = 1'b1;
                    end
                end
            end
            ST_ID_LO: begin
                if (mgmt_ack) begin
                    core_d.id_lo    = mgmt_rdata;
                    core_d.found    = 1'b1;
                    core_d.res_addr = core_q.addr;
                    core_d.st       = ST_DONE;
                end
            end
            ST_BACKOFF: begin
                if (wait_over) begin
                    core_d.st = ST_ID_HI;
                end
            end
            default: core_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '{st: ST_IDLE, default: '0};
        end else begin
            core_q <= core_d;
        end
    end

    probe_wait_timer #(
        .WAIT_CYCLES(WAIT_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wait_load),
        .run    (core_q.st == ST_BACKOFF),
        .expired(wait_over)
    );

    probe_id_pack #(
        .DATA_W  (DATA_W),
        .REV_BITS(REV_BITS)
    ) u_pack (
        .id_hi    (core_q.id_hi),
        .id_lo    (core_q.id_lo),
        .full_id  (phy_id),
        .masked_id(model_id)
    );

    assign mgmt_req = (core_q.st == ST_ID_HI) || (core_q.st == ST_ID_LO);
    assign mgmt_phy = core_q.addr;
    assign mgmt_reg = (core_q.st == ST_ID_LO) ? REG_W'(ID2_REG) : REG_W'(ID1_REG);
    assign done     = (core_q.st == ST_DONE);
    assign found    = core_q.found;
    assign phy_addr = core_q.res_addr;

endmodule

// File: rtl/probe_chk.sv
module probe_chk #(
    parameter int ADDR_W  = 5,
    parameter int REG_W   = 5,
    parameter int DATA_W  = 16,
    parameter int ID1_REG = 2,
    parameter int ID2_REG = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mgmt_req,
    input logic [ADDR_W-1:0] mgmt_phy,
    input logic [REG_W-1:0]  mgmt_reg,
    input logic              mgmt_ack,
    input logic [DATA_W-1:0] mgmt_rdata,
    input logic              done,
    input logic              found
);

    localparam logic [DATA_W-1:0] ABSENT    = {DATA_W{1'b1}};
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_req && !mgmt_ack |=> mgmt_req && $stable(mgmt_phy) && $stable(mgmt_reg));

    a_r5_second_read_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_req && mgmt_ack && mgmt_reg == REG_W'(ID1_REG) && mgmt_rdata != ABSENT
        |=> mgmt_req && mgmt_reg == REG_W'(ID2_REG) && mgmt_phy == $past(mgmt_phy));

    a_r3_next_address: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_req && mgmt_ack && mgmt_reg == REG_W'(ID1_REG) && mgmt_rdata == ABSENT
        && mgmt_phy != LAST_ADDR
        |=> mgmt_req && mgmt_phy == ADDR_W'($past(mgmt_phy) + 1'b1));

    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        done && start |=> !done && !found && mgmt_req);

    a_r11_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mgmt_req);

    a_r5_found_only_done: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> done);

endmodule

bind phy_probe probe_chk #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .DATA_W (DATA_W),
    .ID1_REG(ID1_REG),
    .ID2_REG(ID2_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mgmt_req  (mgmt_req),
    .mgmt_phy  (mgmt_phy),
    .mgmt_reg  (mgmt_reg),
    .mgmt_ack  (mgmt_ack),
    .mgmt_rdata(mgmt_rdata),
    .done      (done),
    .found     (found)
);

// File: tb/tb_phy_probe.sv
module tb_phy_probe;

    localparam int CLK_PERIOD = 10;
    localparam int CPM        = 5;
    localparam int WMS        = 10;
    localparam int MAXP       = 11;
    localparam int GAP        = CPM * WMS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mgmt_req;
    logic [4:0]  mgmt_phy;
    logic [4:0]  mgmt_reg;
    logic        mgmt_ack = 1'b0;
    logic [15:0] mgmt_rdata = '0;
    logic        done, found;
    logic [4:0]  phy_addr;
    logic [31:0] phy_id, model_id;

    always #(CLK_PERIOD / 2) clk = ~clk;

    phy_probe #(.CYCLES_PER_MS(CPM), .WAIT_MS(WMS), .MAX_PASSES(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mgmt_req(mgmt_req), .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg),
        .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata),
        .done(done), .found(found), .phy_addr(phy_addr),
        .phy_id(phy_id), .model_id(model_id)
    );

    typedef struct {
        int phy;
        int rg;
        int gap;
    } item_t;

    item_t exp_q[$];
    item_t cur;
    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit timed_out = 0;
    int m_addr, m_pass, lat, lat_cnt, pass_seen, low_run;
    logic [15:0] m_id1, m_id2;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Responder model and scoreboard monitor.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) timed_out = 1;
        if (mgmt_ack) begin
            mgmt_ack = 1'b0;
            if (!mgmt_req) low_run++;
        end else if (mgmt_req) begin
            if (lat_cnt < lat) begin
                lat_cnt++;
            end else begin
                lat_cnt = 0;
                if (mgmt_phy == 5'd0 && mgmt_reg == 5'd2) pass_seen++;
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R3 unexpected request actual=%0d/%0d expected=none",
                             mgmt_phy, mgmt_reg);
                end else begin
                    cur = exp_q.pop_front();
                    chk("R3 request address", 32'(mgmt_phy), 32'(cur.phy));
                    chk("R5 request register", 32'(mgmt_reg), 32'(cur.rg));
                    if (cur.gap >= 0) chk("R7 back-off gap", 32'(low_run), 32'(cur.gap));
                end
                low_run = 0;
                if (mgmt_phy == 5'(m_addr) && pass_seen >= m_pass)
                    mgmt_rdata = (mgmt_reg == 5'd2) ? m_id1 : m_id2;
                else
                    mgmt_rdata = 16'hFFFF;
                mgmt_ack = 1'b1;
            end
        end else begin
            low_run++;
        end
    end

    // Driver: pushes the expected request sequence, then runs one discovery.
    task automatic run_case(input int addr, input int pass, input logic [15:0] id1,
                            input logic [15:0] id2, input int latency, input bit poke);
        bit hit = 0;
        logic [31:0] eid;
        m_addr = addr; m_pass = pass; m_id1 = id1; m_id2 = id2;
        lat = latency; lat_cnt = 0; pass_seen = 0;
        exp_q.delete();
        for (int p = 1; p <= MAXP && !hit; p++) begin
            for (int a = 0; a < 32 && !hit; a++) begin
                exp_q.push_back('{a, 2, (a == 0) ? ((p == 1) ? -1 : GAP) : 0});
                if (a == addr && p >= pass) begin
                    exp_q.push_back('{a, 3, 0});
                    hit = 1;
                end
            end
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R2 done cleared", 32'(done), 0);
        chk("R2 found cleared", 32'(found), 0);
        chk("R2 id cleared", phy_id, 0);
        if (poke) begin
            repeat (30) @(negedge clk);
            start = 1'b1;           // R9: must be ignored mid-scan
            @(negedge clk); start = 1'b0;
        end
        while (!done && !timed_out) @(negedge clk);
        eid = hit ? {id1, id2} : 32'h0;
        chk("R3 all requests seen", 32'(exp_q.size()), 0);
        chk("R5 found", 32'(found), 32'(hit));
        chk("R5 phy_addr", 32'(phy_addr), hit ? 32'(addr) : 0);
        chk("R5 phy_id", phy_id, eid);
        chk("R6 model_id", model_id, eid & 32'hFFFF_FFF0);
        if (!hit) chk("R8 sweep count", 32'(pass_seen), MAXP);
        repeat (20) @(negedge clk);
        chk("R11 done held", 32'(done), 1);
        chk("R11 req low", 32'(mgmt_req), 0);
        chk("R11 phy_id held", phy_id, eid);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 req in reset", 32'(mgmt_req), 0);
        chk("R1 done in reset", 32'(done), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 req idle", 32'(mgmt_req), 0);
        chk("R1 found idle", 32'(found), 0);
        run_case(5, 1, 16'h0022, 16'h5613, 0, 0);    // R3 R5 R6 basic
        run_case(31, 3, 16'h0181, 16'h4405, 2, 1);   // R7 R9 last address, later pass
        run_case(0, 99, 16'h0000, 16'h0000, 1, 0);   // R8 nobody answers
        run_case(0, 1, 16'h0000, 16'hABCD, 1, 0);    // R4 zero id is a responder
        run_case(17, 11, 16'h0141, 16'h0CC2, 0, 0);  // R8 found on final sweep
        if (timed_out) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (timed_out);
        repeat (5) @(negedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule